// File: doc/BRIEF.md
# Edge-Triggered Port Interrupt Vector

This block is the interrupt part of one eight-pin general-purpose port. Each pin passes through a synchronizer. The block then watches for the edge that software selected for that pin and latches a pending flag when the edge occurs. Flags whose pin is enabled are merged into one registered interrupt request. A priority encoder presents a vector code that names the lowest-numbered enabled pending pin.

Software uses a small register interface with four half-word locations. The first is the vector. The others hold the edge-select bits, the enable bits and the flags. An interrupt handler normally reads the vector, and that access also retires the pin it reports. Software may also write the flag register directly, either to raise an interrupt from code or to discard pending events. An edge-select write can also set a flag when the newly chosen edge already matches the pin level.

Top module: `port_irq_vector`

## Requirements
- R1: After reset the edge-select, enable and flag registers read 0, the vector reads 0 and `irq_o` is low.
- R2: With edge-select bit n at 0, a low-to-high transition on pin n sets flag n, and a high-to-low transition does not.
- R3: With edge-select bit n at 1, a high-to-low transition on pin n sets flag n, and a low-to-high transition does not.
- R4: A pin that holds a constant level never sets its flag, however long the level lasts.
- R5: The vector reads 0 when no enabled flag is pending. Otherwise it reads 2*(n+1), where n is the lowest-numbered pin whose flag and enable bit are both 1. Pin 0 therefore gives 2 and pin 7 gives 16. Flags whose enable bit is 0 do not change the vector.
- R6: `irq_o` is high one cycle after any flag is set together with its enable bit, and low one cycle after no such pair remains.
- R7: A read or a write of the vector with both byte strobes set clears only the flag that the vector names. A vector access with only one strobe set returns 0 and changes no flag.
- R8: A write to the flag register loads the flags from the write data, which both sets and clears them.
- R9: A write to the edge-select register sets flag n when bit n changes and the new edge matches the present level of pin n. This means rising is selected while the pin is low, or falling is selected while the pin is high. A bit that keeps its value sets nothing.
- R10: If a selected edge on a pin arrives in the same cycle as a vector access or a flag write that would clear that pin's flag, the flag ends up set.
- R11: Address 0 is the vector, 1 is edge select, 2 is enable and 3 is the flag register. Pin n maps to data bit n. Bits 15:8 read as 0. Writes to addresses 1 to 3 take effect only when strobe bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 8 | Asynchronous pin levels |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_be | input | 2 | Byte strobes, bit 0 is the low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to create from the ports is a pin edge that lands in exactly the same cycle as a vector access that retires the same pin. The pin change passes through two synchronizer stages and an edge register, so the edge shows up as a one-cycle event two clock edges after the pin is driven. The stimulus first makes pin 0 the pending top-priority pin. It then drives pin 0 high at one falling clock edge and waits one falling edge. It strobes the vector read at the next falling edge, so the read and the detected edge reach the flag register on the same rising edge. A second order-sensitive case is the edge-select write. That write is staged against a settled pin level in both directions, and again with an unchanged value.

// File: rtl/port_irq_vector.sv
module port_irq_vector #(
  parameter int N_PINS      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pins_i,
  input  logic [1:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  localparam int VEC_W = $clog2(2 * N_PINS + 1);
  localparam logic [1:0] A_VEC = 2'd0, A_EDGE = 2'd1, A_EN = 2'd2, A_FLAG = 3'd3;

  logic [N_PINS-1:0] sync_q [SYNC_STAGES];
  logic [N_PINS-1:0] lvl, lvl_prev;
  logic [N_PINS-1:0] ies, en, flag;
  logic [N_PINS-1:0] pend, top_mask, edge_hit, ies_set, set, flag_d, new_val;
  logic [VEC_W-1:0]  top_code;
  logic              irq_q;
  logic              vec_acc, edge_wr, en_wr, flag_wr, low_wr;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:N_PINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      lvl_prev <= '0;
    end else begin
      sync_q[0] <= pins_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      lvl_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl      = sync_q[SYNC_STAGES-1];
  assign edge_hit = (lvl & ~lvl_prev & ~ies) | (~lvl & lvl_prev & ies);

  assign low_wr  = bus_wr && bus_be[0];
  assign vec_acc = (bus_rd || bus_wr) && bus_addr == A_VEC && (&bus_be);
  assign edge_wr = low_wr && bus_addr == A_EDGE;
  assign en_wr   = low_wr && bus_addr == A_EN;
  assign flag_wr = low_wr && bus_addr == A_FLAG;
  assign new_val = bus_wdata[N_PINS-1:0];

  assign ies_set = edge_wr ? ((new_val ^ ies) & ~(new_val ^ lvl)) : '0;
  assign set     = edge_hit | ies_set;
  assign pend    = flag & en;

  always_comb begin
    top_mask = '0;
    top_code = '0;
    for (int i = N_PINS - 1; i >= 0; i--) begin
      if (pend[i]) begin
        top_mask    = '0;
        top_mask[i] = 1'b1;
        top_code    = VEC_W'(2 * (i + 1));
      end
    end
  end

  assign flag_d = (flag_wr ? new_val : (flag & ~(vec_acc ? top_mask : '0))) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ies   <= '0;
      en    <= '0;
      flag  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (edge_wr) ies <= new_val;
      if (en_wr)   en  <= new_val;
      flag  <= flag_d;
      irq_q <= |pend;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_VEC:   bus_rdata = (&bus_be) ? DATA_W'(top_code) : '0;
        A_EDGE:  bus_rdata = DATA_W'(ies);
        A_EN:    bus_rdata = DATA_W'(en);
        default: bus_rdata = DATA_W'(flag);
      endcase
    end
  end

  // R2, R3, R10: a detected edge always leaves its flag set
  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((flag & $past(edge_hit)) == $past(edge_hit)));

  // R4, R7: with no write, no vector access and no event, flags hold
  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr && !vec_acc && set == '0) |=> (flag == $past(flag)));

  // R7: a full vector access retires the named pin
  a_r7_vec_clears_top: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_acc && pend != '0 && (top_mask & set) == '0) |=> ((flag & $past(top_mask)) == '0));

  // R5: the code names the lowest enabled pending pin
  a_r5_code_names_top: assert property (@(posedge clk) disable iff (!rst_n)
    (top_code != '0) |->
      ((pend & ((N_PINS'(1) << (top_code >> 1)) - N_PINS'(1))) == (N_PINS'(1) << ((top_code >> 1) - 1))));

  a_r5_idle_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (top_code == '0));

  // R6: no enables, no request
  a_r6_no_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !irq_o);

endmodule

// File: tb/test_port_irq_vector.sv
module test_port_irq_vector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins_i = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  port_irq_vector i_port_irq_vector (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [1:0] be, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = '0;
  endtask

  task automatic drive(input logic [7:0] v);
    @(negedge clk);
    pins_i = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    rd(2'd1, 2'b11, d); chk("R1 edge select", d, 16'h0);
    rd(2'd2, 2'b11, d); chk("R1 enable", d, 16'h0);
    rd(2'd3, 2'b11, d); chk("R1 flags", d, 16'h0);
    rd(2'd0, 2'b11, d); chk("R1 vector", d, 16'h0);
  endtask

  task automatic t_rise;
    logic [15:0] d;
    drive(8'h01);
    rd(2'd3, 2'b11, d); chk("R2 rise sets", d, 16'h01);
    wr(2'd3, 2'b11, 16'h0);
    drive(8'h00);
    rd(2'd3, 2'b11, d); chk("R2 fall ignored", d, 16'h00);
  endtask

  task automatic t_fall;
    logic [15:0] d;
    wr(2'd1, 2'b11, 16'h02);
    rd(2'd3, 2'b11, d); chk("R9 falling chosen, pin low", d, 16'h00);
    drive(8'h02);
    rd(2'd3, 2'b11, d); chk("R3 rise ignored", d, 16'h00);
    drive(8'h00);
    rd(2'd3, 2'b11, d); chk("R3 fall sets", d, 16'h02);
    wr(2'd1, 2'b11, 16'h00);
    wr(2'd3, 2'b11, 16'h00);
  endtask

  task automatic t_static;
    logic [15:0] d;
    drive(8'hF0);
    wr(2'd3, 2'b11, 16'h0);
    repeat (20) @(negedge clk);
    rd(2'd3, 2'b11, d); chk("R4 high level quiet", d, 16'h00);
    drive(8'h00);
    repeat (20) @(negedge clk);
    rd(2'd3, 2'b11, d); chk("R4 low level quiet", d, 16'h00);
  endtask

  task automatic t_vector;
    logic [15:0] d;
    wr(2'd3, 2'b11, 16'hA4);
    rd(2'd0, 2'b11, d); chk("R5 disabled flags give 0", d, 16'd0);
    chk("R6 irq low while disabled", {15'd0, irq_o}, 16'd0);
    wr(2'd2, 2'b11, 16'hFF);
    @(negedge clk);
    chk("R6 irq high", {15'd0, irq_o}, 16'd1);
    rd(2'd0, 2'b11, d); chk("R5 pin 2 code", d, 16'd6);
    rd(2'd0, 2'b11, d); chk("R7 read retired pin 2", d, 16'd12);
    rd(2'd3, 2'b11, d); chk("R7 only top cleared", d, 16'h80);
    chk("R6 irq held with pin 7 left", {15'd0, irq_o}, 16'd1);
    wr(2'd2, 2'b11, 16'h7F);
    rd(2'd0, 2'b11, d); chk("R5 pin 7 disabled", d, 16'd0);
    rd(2'd3, 2'b11, d); chk("R5 disabled flag kept", d, 16'h80);
    chk("R6 irq low", {15'd0, irq_o}, 16'd0);
    wr(2'd2, 2'b11, 16'hFF);
    rd(2'd0, 2'b11, d); chk("R5 pin 7 code", d, 16'd16);
    wr(2'd3, 2'b11, 16'h80);
    wr(2'd0, 2'b11, 16'h0);
    rd(2'd3, 2'b11, d); chk("R7 write retires", d, 16'h00);
    @(negedge clk);
    chk("R6 irq drops", {15'd0, irq_o}, 16'd0);
  endtask

  task automatic t_partial;
    logic [15:0] d;
    wr(2'd3, 2'b11, 16'h01);
    rd(2'd0, 2'b01, d); chk("R7 half read gives 0", d, 16'd0);
    wr(2'd0, 2'b10, 16'h0);
    rd(2'd3, 2'b11, d); chk("R7 partial access keeps flag", d, 16'h01);
    wr(2'd3, 2'b10, 16'h0);
    rd(2'd3, 2'b11, d); chk("R11 upper strobe ignored", d, 16'h01);
    wr(2'd3, 2'b01, 16'hFF03);
    rd(2'd3, 2'b11, d); chk("R11 upper byte zero", d, 16'h0003);
    wr(2'd3, 2'b11, 16'h0);
  endtask

  task automatic t_sw;
    logic [15:0] d;
    wr(2'd2, 2'b11, 16'h02);
    wr(2'd3, 2'b11, 16'h5A);
    rd(2'd3, 2'b11, d); chk("R8 flags loaded", d, 16'h5A);
    @(negedge clk);
    chk("R8 software irq", {15'd0, irq_o}, 16'd1);
    rd(2'd0, 2'b11, d); chk("R8 vector pin 1", d, 16'd4);
    wr(2'd3, 2'b11, 16'h00);
    rd(2'd3, 2'b11, d); chk("R8 flags cleared", d, 16'h00);
    wr(2'd2, 2'b11, 16'h00);
  endtask

  task automatic t_ies;
    logic [15:0] d;
    drive(8'h08);
    wr(2'd3, 2'b11, 16'h0);
    wr(2'd1, 2'b11, 16'h08);
    rd(2'd3, 2'b11, d); chk("R9 falling chosen, pin high", d, 16'h08);
    wr(2'd3, 2'b11, 16'h0);
    wr(2'd1, 2'b11, 16'h08);
    rd(2'd3, 2'b11, d); chk("R9 unchanged bit", d, 16'h00);
    wr(2'd1, 2'b11, 16'h09);
    rd(2'd3, 2'b11, d); chk("R9 falling chosen, pin low", d, 16'h00);
    wr(2'd1, 2'b11, 16'h00);
    rd(2'd3, 2'b11, d); chk("R9 rising chosen, pin low", d, 16'h01);
    wr(2'd3, 2'b11, 16'h0);
    drive(8'h00);
    rd(2'd3, 2'b11, d); chk("R9 cleanup", d, 16'h00);
  endtask

  task automatic t_collide;
    logic [15:0] d;
    wr(2'd2, 2'b11, 16'h01);
    wr(2'd3, 2'b11, 16'h01);
    @(negedge clk);
    pins_i = 8'h01;
    @(negedge clk);
    rd(2'd0, 2'b11, d); chk("R10 vector at edge", d, 16'd2);
    rd(2'd3, 2'b11, d); chk("R10 edge survives clear", d, 16'h01);
    wr(2'd3, 2'b11, 16'h0);
    wr(2'd2, 2'b11, 16'h0);
    drive(8'h00);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_static();
    t_vector();
    t_partial();
    t_sw();
    t_ies();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule